// File: doc/BRIEF.md
# Parallel ATA Strobe Timing Generator

This block drives the read and write strobes of a parallel ATA channel for one programmed-I/O or multiword-DMA transfer cycle at a time. All phase lengths come from one packed 32-bit timing word. The word holds separate active and inactive lengths for data transfers and for task-file (command register) accesses, and a separate set-up length for each of the two access kinds. Each phase lasts the field value plus one clock.

A request is a valid/ready handshake carrying a direction flag and an access-kind flag. The block raises `req_ready` only while idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester may hold `req_valid` high for as long as it likes: there is no back-pressure beyond the wait for idle, and nothing is queued. While a cycle runs, `busy` is high. Each cycle runs a set-up phase with both strobes high, then an active phase with the selected strobe low, then an inactive phase with both strobes high. `done` pulses during the last clock of the inactive phase.

Top module: `pata_strobe_gen`

## Requirements
- R1: After reset, `busy` and `done` are 0, `req_ready` is 1, and `rd_strobe_n` and `wr_strobe_n` are both 1.
- R2: `req_ready` is 1 exactly when `busy` is 0. A request is accepted only on a rising edge where `req_valid` and `req_ready` are both 1. A `req_valid` seen while busy has no effect on the cycle in progress and starts no further cycle.
- R3: The first busy cycles form a set-up phase in which both strobes are high. For a data access (`req_cmd`=0) it lasts bits 24:22 plus 1 clocks. For a task-file access (`req_cmd`=1) it lasts bits 27:25 plus 1 clocks.
- R4: For a data access, the active phase lasts bits 8:4 plus 1 clocks and directly follows the set-up phase.
- R5: For a data access, the inactive phase lasts bits 3:0 plus 1 clocks and directly follows the active phase. Both strobes are high during it.
- R6: For a task-file access, the active phase lasts bits 17:13 plus 1 clocks and the inactive phase lasts bits 12:9 plus 1 clocks.
- R7: `req_write`=1 selects `wr_strobe_n` and `req_write`=0 selects `rd_strobe_n` for the active phase. The other strobe stays high for the whole cycle. The two strobes are never low together.
- R8: `done` is high for exactly the last clock of the inactive phase. `busy` is 0 in the following clock.
- R9: The timing word, `req_write` and `req_cmd` are sampled when the request is accepted. Changes to them while busy do not alter the cycle in progress.
- R10: Bits 31:28 and 21:18 of the timing word have no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timing_word | input | 32 | Packed phase lengths |
| req_valid | input | 1 | Request for one strobe cycle |
| req_ready | output | 1 | High while idle; request accepted when both are high |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_cmd | input | 1 | 1 = task-file timing, 0 = data timing |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse in the last inactive clock |

## Verification
The hardest case to reach from the ports is a cycle in which the timing word, the direction, the access kind and `req_valid` all change while the cycle runs. A plain requester would hold them steady. The stress requests re-randomize all four on every clock of the busy period and then compare each clock against a waveform predicted from the values captured at acceptance. This covers both the sampling rule and the rule that requests are ignored while busy. Fields at their extremes, all-zero and all-ones with only the ignored bits varied, are run as directed cases.

// File: rtl/pata_tmg_pkg.sv
package pata_tmg_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 5;

  // field positions that the decoder relies on
  localparam int D_REC_LSB = 0;   localparam int D_REC_W = 4;
  localparam int D_ACT_LSB = 4;   localparam int D_ACT_W = 5;
  localparam int C_REC_LSB = 9;   localparam int C_REC_W = 4;
  localparam int C_ACT_LSB = 13;  localparam int C_ACT_W = 5;
  localparam int D_SET_LSB = 22;  localparam int D_SET_W = 3;
  localparam int C_SET_LSB = 25;  localparam int C_SET_W = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup_len;
    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] rec_len;
  } phase_lens_t;
endpackage

// File: rtl/pata_tmg_decode.sv
module pata_tmg_decode
  import pata_tmg_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] word,
  input  logic         is_cmd,
  output phase_lens_t  lens
);
  phase_lens_t data_l, cmd_l;

  always_comb begin
    data_l.setup_len = CNT_W'(word[D_SET_LSB +: D_SET_W]);
    data_l.act_len   = CNT_W'(word[D_ACT_LSB +: D_ACT_W]);
    data_l.rec_len   = CNT_W'(word[D_REC_LSB +: D_REC_W]);
    cmd_l.setup_len  = CNT_W'(word[C_SET_LSB +: C_SET_W]);
    cmd_l.act_len    = CNT_W'(word[C_ACT_LSB +: C_ACT_W]);
    cmd_l.rec_len    = CNT_W'(word[C_REC_LSB +: C_REC_W]);
    lens = is_cmd ? cmd_l : data_l;
  end
endmodule

// File: rtl/pata_tmg_seq.sv
module pata_tmg_seq
  import pata_tmg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  phase_lens_t lens_in,
  input  logic        write_in,
  output phase_e      phase,
  output logic        last_clk,
  output logic        write_q
);
  phase_lens_t      lens_q;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign last_clk = (phase == PH_REC) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      lens_q  <= '0;
      write_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_SETUP;
          cnt     <= lens_in.setup_len;
          lens_q  <= lens_in;
          write_q <= write_in;
        end
        PH_SETUP: if (cnt_zero) begin
          phase <= PH_ACT;
          cnt   <= lens_q.act_len;
        end else cnt <= cnt - 1'b1;
        PH_ACT: if (cnt_zero) begin
          phase <= PH_REC;
          cnt   <= lens_q.rec_len;
        end else cnt <= cnt - 1'b1;
        PH_REC: if (cnt_zero) phase <= PH_IDLE;
                else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_LENS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(lens_q) && $stable(write_q)); // R9
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start) |=> (phase == PH_SETUP)); // R3
  AST_ACT_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACT) |-> ($past(phase) == PH_SETUP || $past(phase) == PH_ACT)); // R4
endmodule

// File: rtl/pata_strobe_gen.sv
module pata_strobe_gen
  import pata_tmg_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] timing_word,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic         req_cmd,
  output logic         rd_strobe_n,
  output logic         wr_strobe_n,
  output logic         busy,
  output logic         done
);
  phase_lens_t lens;
  phase_e      phase;
  logic        last_clk, write_q, accept;

  pata_tmg_decode #(.W(W)) dec_i (
    .word   (timing_word),
    .is_cmd (req_cmd),
    .lens   (lens)
  );

  assign accept = req_valid && req_ready;

  pata_tmg_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .lens_in  (lens),
    .write_in (req_write),
    .phase    (phase),
    .last_clk (last_clk),
    .write_q  (write_q)
  );

  assign busy        = (phase != PH_IDLE);
  assign req_ready   = !busy;
  assign done        = last_clk;
  assign rd_strobe_n = !((phase == PH_ACT) && !write_q);
  assign wr_strobe_n = !((phase == PH_ACT) &&  write_q);

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_n || wr_strobe_n); // R7
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy); // R2
  AST_SETUP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rd_strobe_n && wr_strobe_n); // R3
  AST_STROBE_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_n && $past(!rd_strobe_n || !wr_strobe_n)) |-> $past(!rd_strobe_n)); // R7
endmodule

// File: tb/pata_strobe_gen_tb_top.sv
module pata_strobe_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timing_word = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_cmd = 1'b0;
  logic        req_ready, rd_strobe_n, wr_strobe_n, busy, done;
  int          checks = 0, failures = 0;
  bit          timed_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pata_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .timing_word(timing_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cmd(req_cmd), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
    .busy(busy), .done(done));

  function automatic int f_setup(input logic [31:0] w, input logic c);
    return c ? int'(w[27:25]) : int'(w[24:22]);
  endfunction
  function automatic int f_act(input logic [31:0] w, input logic c);
    return c ? int'(w[17:13]) : int'(w[8:4]);
  endfunction
  function automatic int f_rec(input logic [31:0] w, input logic c);
    return c ? int'(w[12:9]) : int'(w[3:0]);
  endfunction

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s {rd,wr,busy,done,ready} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // one request; stress re-randomizes every input while busy (R2, R9)
  task automatic run_req(input logic [31:0] w, input logic c, input logic wr,
                         input bit stress, input string extra);
    int s, a, h, total;
    @(negedge clk);
    timing_word = w; req_cmd = c; req_write = wr; req_valid = 1'b1;
    check({extra, " R2 idle ready"}, {rd_strobe_n, wr_strobe_n, busy, done, req_ready}, 5'b11001);
    s = f_setup(w, c); a = f_act(w, c); h = f_rec(w, c);
    total = s + a + h + 3;
    @(posedge clk);
    for (int k = 1; k <= total + 1; k++) begin
      logic [4:0] exp;
      string tag;
      @(negedge clk);
      if (k <= s + 1) begin
        exp = 5'b11100; tag = "R3 setup";
      end else if (k <= s + a + 2) begin
        exp = wr ? 5'b10100 : 5'b01100;
        tag = c ? "R6 cmd active R7" : "R4 data active R7";
      end else if (k <= total) begin
        exp = (k == total) ? 5'b11110 : 5'b11100;
        tag = (k == total) ? "R8 done" : (c ? "R6 cmd inactive" : "R5 data inactive");
      end else begin
        exp = 5'b11001; tag = "R8 idle after done";
      end
      check({extra, " ", tag}, {rd_strobe_n, wr_strobe_n, busy, done, req_ready}, exp);
      if (stress && k <= total) begin
        timing_word = $urandom; req_cmd = 1'($urandom);
        req_write = 1'($urandom); req_valid = 1'($urandom);
      end else req_valid = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    timed_out = 1'b1;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {rd_strobe_n, wr_strobe_n, busy, done, req_ready}, 5'b11001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {rd_strobe_n, wr_strobe_n, busy, done, req_ready}, 5'b11001);

    run_req(32'h0000_0000, 1'b0, 1'b0, 0, "min data read");
    run_req(32'h0000_0000, 1'b1, 1'b1, 0, "min cmd write");
    run_req(32'h0FC3_FFFF, 1'b0, 1'b1, 0, "max data write");
    run_req(32'h0FC3_FFFF, 1'b1, 1'b0, 0, "max cmd read");
    run_req(32'hF03C_0000 | 32'h0281_2C73, 1'b0, 1'b0, 0, "R10 ignored bits set");
    run_req(32'h0281_2C73, 1'b0, 1'b0, 0, "R10 ignored bits clear");
    run_req(32'h0A40_6A35, 1'b1, 1'b1, 1, "R9 R2 stress cmd");
    run_req(32'h0A40_6A35, 1'b0, 1'b0, 1, "R9 R2 stress data");
    for (int n = 0; n < 250 && !timed_out; n++)
      run_req($urandom, 1'($urandom), 1'($urandom), 1'($urandom), "random");

    if (timed_out) begin
      failures++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule